// File: doc/BRIEF.md
# Multi-Pass Ping-Pong Buffer Sequencer

This block steps one block of `DEPTH` data words through a programmed series of processing passes. Between passes the datapath hardware is assumed to be swapped out for a new function. Two external frame buffers, each large enough for the whole block, take turns. In each pass one buffer is the source and the other is the destination, and the roles swap before the next pass. The datapath is a pipe with a fixed latency of `PIPE_LAT` cycles. For every read the sequencer therefore issues the matching write exactly that many cycles later, at the same address.

A job starts with a one-cycle `start` pulse that captures the number of passes (1 to 15). For each pass the sequencer first requests a new datapath configuration and waits for the acknowledge. It then streams all `DEPTH` read addresses and waits for the pipe to drain. After that it flips the buffer select and either starts the next pass or finishes. At the end it raises a one-cycle `done` pulse and reports which buffer holds the final result. The source data of a job is expected in buffer 0.

Top module: `pingpong_pass_ctrl`

## Requirements
- R1: A `start` pulse seen while idle with `num_passes` between 1 and 15 runs exactly that many passes. A `start` with `num_passes` = 0 leaves the block idle. A `start` seen while busy is ignored and does not change the pass count.
- R2: Each pass begins with `cfg_req` high. It stays high until the cycle in which `cfg_ack` is sampled high, and then falls. `rd_en` is low while `cfg_req` is high.
- R3: In each pass `rd_en` is high for exactly `DEPTH` consecutive cycles. `rd_addr` runs from 0 to `DEPTH`-1, rising by one each cycle.
- R4: Each read is followed by a write exactly `PIPE_LAT` cycles later to the same address, so `wr_addr` also runs from 0 to `DEPTH`-1 once per pass.
- R5: `buf_sel` is 0 during the first pass and inverts for each following pass. It stays constant within a pass. Value 0 means read buffer 0 and write buffer 1; value 1 means the reverse.
- R6: After the last write of the last pass, `done` is high for exactly one cycle. At the same time `busy` falls and `done_buf` shows the buffer written by the last pass: 1 for an odd pass count, 0 for an even one.
- R7: After reset, `cfg_req`, `rd_en`, `wr_en`, `busy`, `done` and `buf_sel` are all 0.
- R8: The configuration request of a pass is raised only after every write of the previous pass has been issued.
- R9: `busy` is high in every cycle from the accepted `start` up to the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle job start pulse |
| num_passes | input | PASS_W | Number of passes, captured on an accepted start |
| cfg_req | output | 1 | Request to load the next datapath configuration |
| cfg_ack | input | 1 | Configuration loaded |
| rd_en | output | 1 | Read strobe to the source buffer |
| rd_addr | output | ADDR_W | Read word address |
| wr_en | output | 1 | Write strobe to the destination buffer |
| wr_addr | output | ADDR_W | Write word address |
| buf_sel | output | 1 | Source buffer index; the destination is its inverse |
| busy | output | 1 | A job is in progress |
| pass_num | output | PASS_W | Current pass number, counted from 1 |
| done | output | 1 | One-cycle end-of-job pulse |
| done_buf | output | 1 | Buffer holding the final result |

## Verification
The assertions assume that `cfg_ack` is raised only while `cfg_req` is high, and only as a single-cycle pulse. They also assume that `start` is a single-cycle pulse. The bench drives the acknowledge from a counter that starts when it sees the request. It drops the acknowledge in the cycle right after, and applies every `start` for exactly one cycle. The bench also sends one `start` in the middle of a running job. This checks that the busy-time guard holds even though the extra pulse is legal at the port.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RECONFIG,
        S_RUN,
        S_DRAIN,
        S_NEXT
    } ppc_state_e;

endpackage

// File: rtl/ppc_addr_ctr.sv
module ppc_addr_ctr #(
    parameter int DEPTH  = 262144,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (clr) begin
            addr_d = '0;
        end else if (step) begin
            addr_d = (addr_q == TOP) ? '0 : addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;
    assign last = (addr_q == TOP);

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q <= TOP);  // R3

endmodule

// File: rtl/ppc_pass_ctr.sv
module ppc_pass_ctr #(
    parameter int PASS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PASS_W-1:0] load_val,
    input  logic              adv,
    output logic [PASS_W-1:0] idx,
    output logic              final_pass
);

    typedef struct packed {
        logic [PASS_W-1:0] idx;
        logic [PASS_W-1:0] target;
    } pass_t;

    pass_t pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        if (load) begin
            pc_d.idx    = PASS_W'(1);
            pc_d.target = load_val;
        end else if (adv) begin
            pc_d.idx = pc_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign idx        = pc_q.idx;
    assign final_pass = (pc_q.idx == pc_q.target);

    AST_PASS_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (pc_q.idx < pc_q.target));  // R1

endmodule

// File: rtl/pingpong_pass_ctrl.sv
module pingpong_pass_ctrl
    import ppc_pkg::*;
#(
    parameter int DEPTH    = 262144,
    parameter int PIPE_LAT = 4,
    parameter int PASS_W   = 4,
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PASS_W-1:0] num_passes,
    output logic              cfg_req,
    input  logic              cfg_ack,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              buf_sel,
    output logic              busy,
    output logic [PASS_W-1:0] pass_num,
    output logic              done,
    output logic              done_buf
);

    typedef struct packed {
        ppc_state_e          state;
        logic                buf_sel;
        logic                done;
        logic                done_buf;
        logic [PIPE_LAT-1:0] lat;
    } ctl_t;

    ctl_t r_d, r_q;

    logic                rd_last, wr_last, final_pass;
    logic                pass_load, pass_adv, addr_clr;
    logic [PIPE_LAT-1:0] lat_shift;

    assign rd_en    = (r_q.state == S_RUN);
    assign wr_en    = r_q.lat[PIPE_LAT-1];
    assign addr_clr = (r_q.state == S_RECONFIG);

    generate
        if (PIPE_LAT == 1) begin : g_lat_one
            assign lat_shift = rd_en;
        end else begin : g_lat_many
            assign lat_shift = {r_q.lat[PIPE_LAT-2:0], rd_en};
        end
    endgenerate

    ppc_addr_ctr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rd_ctr (
        .clk(clk), .rst_n(rst_n), .clr(addr_clr), .step(rd_en),
        .addr(rd_addr), .last(rd_last)
    );

    ppc_addr_ctr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wr_ctr (
        .clk(clk), .rst_n(rst_n), .clr(addr_clr), .step(wr_en),
        .addr(wr_addr), .last(wr_last)
    );

    ppc_pass_ctr #(.PASS_W(PASS_W)) u_pass_ctr (
        .clk(clk), .rst_n(rst_n), .load(pass_load), .load_val(num_passes),
        .adv(pass_adv), .idx(pass_num), .final_pass(final_pass)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.lat   = lat_shift;
        pass_load = 1'b0;
        pass_adv  = 1'b0;
        unique case (r_q.state)
            S_IDLE: begin
                if (start && (num_passes != '0)) begin
                    r_d.state   = S_RECONFIG;
                    r_d.buf_sel = 1'b0;
                    pass_load   = 1'b1;
                end
            end
            S_RECONFIG: begin
                if (cfg_ack) r_d.state = S_RUN;
            end
            S_RUN: begin
                if (rd_last) r_d.state = S_DRAIN;
            end
            S_DRAIN: begin
                if (wr_en && wr_last) r_d.state = S_NEXT;
            end
            S_NEXT: begin
                r_d.buf_sel = ~r_q.buf_sel;
                if (final_pass) begin
                    r_d.state    = S_IDLE;
                    r_d.done     = 1'b1;
                    r_d.done_buf = ~r_q.buf_sel;
                end else begin
                    r_d.state = S_RECONFIG;
                    pass_adv  = 1'b1;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_req  = (r_q.state == S_RECONFIG);
    assign busy     = (r_q.state != S_IDLE);
    assign buf_sel  = r_q.buf_sel;
    assign done     = r_q.done;
    assign done_buf = r_q.done_buf;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> cfg_req);  // R2
    AST_NO_READ_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !rd_en);  // R2
    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));  // R3
    AST_WR_BEHIND: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |-> (wr_addr < rd_addr));  // R4
    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_RUN || r_q.state == S_DRAIN) |=> $stable(buf_sel));  // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);  // R6
    AST_CFG_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_req) |-> !wr_en);  // R8

endmodule

// File: tb/tb_pingpong_pass_ctrl.sv
module tb_pingpong_pass_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int LAT        = 3;
    localparam int PASS_W     = 4;
    localparam int ADDR_W     = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [PASS_W-1:0] num_passes = '0;
    logic              cfg_ack = 1'b0;
    logic              cfg_req, rd_en, wr_en, buf_sel, busy, done, done_buf;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [PASS_W-1:0] pass_num;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    pingpong_pass_ctrl #(.DEPTH(DEPTH), .PIPE_LAT(LAT), .PASS_W(PASS_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .num_passes(num_passes),
        .cfg_req(cfg_req), .cfg_ack(cfg_ack), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .buf_sel(buf_sel), .busy(busy),
        .pass_num(pass_num), .done(done), .done_buf(done_buf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(cfg_req == 0 && rd_en == 0 && wr_en == 0, "R7 strobes idle",
              {cfg_req, rd_en, wr_en}, 0);
        check(busy == 0 && done == 0 && buf_sel == 0, "R7 status idle",
              {busy, done, buf_sel}, 0);
    endtask

    task automatic test_zero_passes();
        @(negedge clk);
        num_passes = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
        end
        check(busy == 0 && cfg_req == 0 && rd_en == 0, "R1 zero count ignored",
              {busy, cfg_req, rd_en}, 0);
    endtask

    task automatic run_job(input int passes, input int ack_dly, input bit poke);
        int cyc = 0, rises = 0, req_cyc = 0, reads = 0, writes = 0;
        int rd_bad = 0, wr_bad = 0, sel_bad = 0, ovl_bad = 0, busy_bad = 0;
        int wait_cnt = 0, exp_rd = 0, exp_wr = 0, fin_buf = -1;
        int rd_cyc[DEPTH];
        bit prev_req = 1'b0, seen_done = 1'b0;
        @(negedge clk);
        num_passes = PASS_W'(passes);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!seen_done && cyc < 5000) begin
            if (start) start = 1'b0;
            if (cfg_req && !prev_req) begin
                rises++;
                if (writes != DEPTH * (rises - 1)) ovl_bad++;
            end
            prev_req = cfg_req;
            if (cfg_req) req_cyc++;
            if (rd_en) begin
                if (cfg_req || rd_addr != ADDR_W'(exp_rd)) rd_bad++;
                if (buf_sel != 1'((rises - 1) % 2)) sel_bad++;
                rd_cyc[rd_addr] = cyc;
                exp_rd = (exp_rd + 1) % DEPTH;
                reads++;
            end
            if (wr_en) begin
                if (wr_addr != ADDR_W'(exp_wr) || cyc - rd_cyc[wr_addr] != LAT) wr_bad++;
                exp_wr = (exp_wr + 1) % DEPTH;
                writes++;
            end
            if (done) begin
                seen_done = 1'b1;
                fin_buf = int'(done_buf);
                if (busy) busy_bad++;
            end else if (!busy) begin
                busy_bad++;
            end
            if (cfg_ack) begin
                cfg_ack = 1'b0;
            end else if (cfg_req) begin
                wait_cnt++;
                if (wait_cnt > ack_dly) begin
                    cfg_ack = 1'b1;
                    wait_cnt = 0;
                end
            end
            if (poke && cyc == DEPTH / 2) begin
                num_passes = PASS_W'(7);
                start = 1'b1;
            end
            @(negedge clk);
            cyc++;
        end
        cfg_ack = 1'b0;
        start = 1'b0;
        check(seen_done, "R6 done reached", int'(seen_done), 1);
        check(rises == passes, "R1 pass count", rises, passes);
        check(req_cyc == passes * (ack_dly + 1), "R2 request length", req_cyc, passes * (ack_dly + 1));
        check(reads == passes * DEPTH, "R3 read count", reads, passes * DEPTH);
        check(rd_bad == 0, "R3 read order", rd_bad, 0);
        check(writes == passes * DEPTH, "R4 write count", writes, passes * DEPTH);
        check(wr_bad == 0, "R4 write lag and address", wr_bad, 0);
        check(sel_bad == 0, "R5 buffer select per pass", sel_bad, 0);
        check(ovl_bad == 0, "R8 request after last write", ovl_bad, 0);
        check(busy_bad == 0, "R9 busy during job", busy_bad, 0);
        check(fin_buf == passes % 2, "R6 result buffer", fin_buf, passes % 2);
        check(done == 0 && busy == 0, "R6 done single cycle", {done, busy}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();          // R7
        test_zero_passes();    // R1
        run_job(1, 0, 1'b0);   // R1 R2 R3 R4 R6
        run_job(2, 2, 1'b0);   // R5 R8
        run_job(3, 1, 1'b1);   // R1 busy start ignored
        run_job(15, 0, 1'b0);  // R1 largest count
        run_job(4, 3, 1'b0);   // R5 even result buffer
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule